// File: doc/BRIEF.md
# LPC Peripheral Target

This block is the target side of a 4-bit multiplexed LPC-style bus. It watches the host's active-high frame input and the 4-bit LAD input and recognises the start nibble of each host cycle. It then follows one of four nibble sequences. Firmware cycles skip the cycle-type nibble. I/O cycles carry a 16-bit address. Memory and firmware cycles carry a 32-bit address. DMA cycles replace the address with a channel nibble and a size nibble, and they invert the direction bit.

After the host's turnaround the target runs the sync handshake. It passes the cycle to a local register port as a request with address, kind, direction and write data. It holds the long-wait sync code on LAD until the port acknowledges. It then signals ready, returns a read byte when needed, and hands the bus back with a turnaround. Each cycle moves one data byte. For DMA cycles the channel number and the terminal-count flag are kept on sideband outputs.

Top module: `lpc_target`

## Requirements
- R1: A cycle starts only on a clock where `frame_i` is high and `lad_i` holds a start code. 0000 selects an I/O, memory or DMA cycle. 1101 selects a firmware read and 1110 a firmware write, both with `kind_o`=2. Any other value with `frame_i` high leaves the target idle: no request, and `lad_oe` stays low.
- R2: After start code 0000, a cycle-type nibble {0, m, w, 0} gives `kind_o`=1 (memory) when m=1 and `kind_o`=0 (I/O) when m=0. `we_o` equals w. A cycle-type nibble with its two top bits both 1 is dropped, and the target returns to idle.
- R3: A cycle-type nibble {1, 0, d, 0} gives a DMA cycle with `kind_o`=3 and `we_o` = NOT d, so d=0 is a host write. One channel nibble and then one size nibble follow in place of the address.
- R4: In a DMA cycle `dma_chan_o` takes bits 2:0 of the channel nibble and `dma_tc_o` takes bit 3. Both keep their value through every later cycle until the next DMA channel nibble arrives.
- R5: The address arrives most significant nibble first. An I/O cycle has 4 nibbles and `addr_o` shows them zero-extended to 32 bits. Memory and firmware cycles have 8 nibbles, and the top nibble of a firmware address is the device-select field.
- R6: In a host write, two data nibbles follow the address, low nibble first, and form `wdata_o`. In a host read, no data nibbles are sent. In both cases two host turnaround clocks follow, and `req_o` goes high on the next clock.
- R7: While `req_o` is high the target drives 0110 with `lad_oe` high. `req_o` stays high until `ack_i` is sampled high. On the following clock the target drives 0000 for exactly one clock, with `req_o` low.
- R8: In a host read, the byte on `rdata_i` at the acknowledging clock is driven on the two clocks after the ready nibble, low nibble first.
- R9: After the last target-driven nibble, the target drives 1111 for one clock and then lowers `lad_oe`. It is idle again on the clock after that.
- R10: `lad_oe` is high only during the target's sync, ready, read-data and first turnaround clocks.
- R11: `frame_i` high during a cycle aborts it. On the next clock `lad_oe` and `req_o` are low. If `lad_i` held a start code, decoding restarts from that nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Host frame, active high |
| lad_i | input | 4 | LAD value sampled from the bus |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | Target LAD output enable |
| req_o | output | 1 | Local port request |
| kind_o | output | 2 | Cycle kind: 0 I/O, 1 memory, 2 firmware, 3 DMA |
| addr_o | output | 32 | Cycle address |
| we_o | output | 1 | 1 when the host writes |
| wdata_o | output | 8 | Host write byte |
| ack_i | input | 1 | Local port acknowledge |
| rdata_i | input | 8 | Local port read byte |
| dma_chan_o | output | 3 | Last DMA channel |
| dma_tc_o | output | 1 | Last DMA terminal count |

## Verification
The bench sweeps every channel and terminal-count combination in both DMA directions. A design that skipped the DMA direction inversion would report the opposite `we_o` and skip or invent data nibbles. I/O, memory and firmware addresses with walking nibbles expose a reversed nibble order or a wrong address length as a shifted `addr_o`. All thirteen non-start codes and an illegal cycle type are sent, to catch a target that requests on junk. Aborts in mid-address and during sync show whether the bus is released and decoding restarts, and a non-DMA cycle after each DMA cycle exposes sideband values that are cleared too early.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_CHAN, ST_SIZE, ST_HDATA,
    ST_HTAR, ST_SYNC, ST_READY, ST_TDATA, ST_TTAR
  } lpc_st_e;

  typedef enum logic [1:0] {
    K_IO  = 2'd0,
    K_MEM = 2'd1,
    K_FW  = 2'd2,
    K_DMA = 2'd3
  } lpc_kind_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_FW_RD = 4'b1101;
  localparam logic [3:0] NIB_FW_WR = 4'b1110;
  localparam logic [3:0] NIB_WAIT  = 4'b0110;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_PARK  = 4'b1111;
  localparam int         TAR_CLKS  = 2;

  function automatic logic is_fw_start(logic [3:0] n);
    return (n == NIB_FW_RD) || (n == NIB_FW_WR);
  endfunction

  // number of clocks spent in a multi-clock phase
  function automatic int phase_len(lpc_st_e st, lpc_kind_e k,
                                   int io_n, int mem_n, int dat_n);
    case (st)
      ST_ADDR:          return (k == K_IO) ? io_n : mem_n;
      ST_HDATA,
      ST_TDATA:         return dat_n;
      ST_HTAR, ST_TTAR: return TAR_CLKS;
      default:          return 1;
    endcase
  endfunction

  // a target-driven phase means LAD belongs to this block
  function automatic logic target_phase(lpc_st_e st);
    return (st == ST_SYNC) || (st == ST_READY) ||
           (st == ST_TDATA) || (st == ST_TTAR);
  endfunction

endpackage

// File: rtl/lpc_tgt_capture.sv
module lpc_tgt_capture
  import lpc_tgt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DN = 2,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      lad_i,
  input  logic            clr_addr,
  input  logic            sh_addr,
  input  logic            wcap,
  input  logic            chan_en,
  input  logic [CW-1:0]   idx,
  output logic [AW-1:0]   addr,
  output logic [DN*4-1:0] wdata,
  output logic [2:0]      chan,
  output logic            tc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (clr_addr) addr <= '0;
    else if (sh_addr)  addr <= {addr[AW-5:0], lad_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0;
      tc   <= 1'b0;
    end else if (chan_en) begin
      chan <= lad_i[2:0];
      tc   <= lad_i[3];
    end
  end

  // one register per data nibble, low nibble arrives first
  for (genvar g = 0; g < DN; g++) begin : g_wnib
    logic [3:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          nib_q <= '0;
      else if (wcap && (idx == CW'(g)))    nib_q <= lad_i;
    end
    assign wdata[g*4 +: 4] = nib_q;
  end

endmodule

// File: rtl/lpc_tgt_drive.sv
module lpc_tgt_drive
  import lpc_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lpc_st_e       st,
  input  logic [CW-1:0] idx,
  input  logic          ack_take,
  input  logic [DW-1:0] rdata_i,
  output logic [3:0]    lad_o,
  output logic          lad_oe
);

  logic [DW-1:0] rbuf;
  logic [DW-1:0] rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rbuf <= '0;
    else if (ack_take) rbuf <= rdata_i;
  end

  assign rsh = rbuf >> {idx, 2'b00};

  always_comb begin
    lad_oe = 1'b0;
    lad_o  = NIB_PARK;
    case (st)
      ST_SYNC:  begin lad_oe = 1'b1; lad_o = NIB_WAIT;  end
      ST_READY: begin lad_oe = 1'b1; lad_o = NIB_READY; end
      ST_TDATA: begin lad_oe = 1'b1; lad_o = rsh[3:0];  end
      ST_TTAR:  begin lad_oe = (idx == '0); lad_o = NIB_PARK; end
      default:  ;
    endcase
  end

  // R10: output enable never outside the target's own phases
  AST_OE_TARGET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    lad_oe |-> target_phase(st)); // R10

endmodule

// File: rtl/lpc_target.sv
module lpc_target
  import lpc_tgt_pkg::*;
#(
  parameter int IO_NIBS   = 4,
  parameter int MEM_NIBS  = 8,
  parameter int DATA_NIBS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_i,
  input  logic [3:0]            lad_i,
  output logic [3:0]            lad_o,
  output logic                  lad_oe,
  output logic                  req_o,
  output logic [1:0]            kind_o,
  output logic [MEM_NIBS*4-1:0] addr_o,
  output logic                  we_o,
  output logic [DATA_NIBS*4-1:0] wdata_o,
  input  logic                  ack_i,
  input  logic [DATA_NIBS*4-1:0] rdata_i,
  output logic [2:0]            dma_chan_o,
  output logic                  dma_tc_o
);

  localparam int AW = MEM_NIBS * 4;
  localparam int DW = DATA_NIBS * 4;
  localparam int IOW = IO_NIBS * 4;
  localparam int CW = $clog2(MEM_NIBS + DATA_NIBS + TAR_CLKS + 1);

  lpc_st_e       state, st_n;
  lpc_kind_e     kind, kind_n;
  logic          we, we_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          last;
  logic          clr_addr, sh_addr, wcap, chan_en;

  // named events for the checks
  logic ev_start, ev_abort, ev_ack;
  assign ev_start = frame_i && ((lad_i == NIB_START) || is_fw_start(lad_i));
  assign ev_abort = frame_i && (state != ST_IDLE);
  assign ev_ack   = (state == ST_SYNC) && ack_i && !frame_i;

  assign last = (int'(cnt) == phase_len(state, kind, IO_NIBS, MEM_NIBS, DATA_NIBS) - 1);

  always_comb begin
    st_n     = state;
    kind_n   = kind;
    we_n     = we;
    cnt_n    = cnt + 1'b1;
    clr_addr = 1'b0;
    sh_addr  = 1'b0;
    wcap     = 1'b0;
    chan_en  = 1'b0;
    if (frame_i) begin
      cnt_n    = '0;
      clr_addr = 1'b1;
      if (lad_i == NIB_START) begin
        st_n = ST_CTYPE;
      end else if (is_fw_start(lad_i)) begin
        st_n   = ST_ADDR;
        kind_n = K_FW;
        we_n   = (lad_i == NIB_FW_WR);
      end else begin
        st_n = ST_IDLE;
      end
    end else begin
      case (state)
        ST_IDLE: cnt_n = '0;
        ST_CTYPE: begin
          cnt_n = '0;
          if (!lad_i[3]) begin
            kind_n = lad_i[2] ? K_MEM : K_IO;
            we_n   = lad_i[1];
            st_n   = ST_ADDR;
          end else if (!lad_i[2]) begin
            kind_n = K_DMA;
            we_n   = !lad_i[1];
            st_n   = ST_CHAN;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_ADDR: begin
          sh_addr = 1'b1;
          if (last) begin
            cnt_n = '0;
            st_n  = we ? ST_HDATA : ST_HTAR;
          end
        end
        ST_CHAN: begin
          chan_en = 1'b1;
          cnt_n   = '0;
          st_n    = ST_SIZE;
        end
        ST_SIZE: begin
          cnt_n = '0;
          st_n  = we ? ST_HDATA : ST_HTAR;
        end
        ST_HDATA: begin
          wcap = 1'b1;
          if (last) begin
            cnt_n = '0;
            st_n  = ST_HTAR;
          end
        end
        ST_HTAR: if (last) begin
          cnt_n = '0;
          st_n  = ST_SYNC;
        end
        ST_SYNC: begin
          cnt_n = '0;
          if (ack_i) st_n = ST_READY;
        end
        ST_READY: begin
          cnt_n = '0;
          st_n  = we ? ST_TTAR : ST_TDATA;
        end
        ST_TDATA: if (last) begin
          cnt_n = '0;
          st_n  = ST_TTAR;
        end
        ST_TTAR: if (last) begin
          cnt_n = '0;
          st_n  = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= K_IO;
      we    <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= st_n;
      kind  <= kind_n;
      we    <= we_n;
      cnt   <= cnt_n;
    end
  end

  assign req_o  = (state == ST_SYNC);
  assign kind_o = kind;
  assign we_o   = we;

  lpc_tgt_capture #(.AW(AW), .DN(DATA_NIBS), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .lad_i(lad_i),
    .clr_addr(clr_addr), .sh_addr(sh_addr), .wcap(wcap), .chan_en(chan_en),
    .idx(cnt), .addr(addr_o), .wdata(wdata_o), .chan(dma_chan_o), .tc(dma_tc_o)
  );

  lpc_tgt_drive #(.DW(DW), .CW(CW)) u_drv (
    .clk(clk), .rst_n(rst_n), .st(state), .idx(cnt), .ack_take(ev_ack),
    .rdata_i(rdata_i), .lad_o(lad_o), .lad_oe(lad_oe)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && !frame_i) |=> req_o); // R7
  AST_WAIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (lad_oe && lad_o == NIB_WAIT)); // R7
  AST_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (lad_oe && lad_o == NIB_READY && !req_o)); // R7
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (!lad_oe && !req_o)); // R11
  AST_PARK_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && !$past(frame_i)) |-> ($past(lad_o) == NIB_PARK)); // R9
  AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !$rose(req_o)) |-> ($stable(addr_o) && $stable(we_o) && $stable(kind_o))); // R6
  AST_SIDEBAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ($stable(dma_chan_o) && $stable(dma_tc_o))); // R4
  AST_NO_JUNK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && frame_i && !ev_start) |=> (state == ST_IDLE)); // R1

  if (IOW < AW) begin : g_io_chk
    AST_IO_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && kind_o == K_IO) |-> (addr_o[AW-1:IOW] == '0)); // R5
  end

endmodule

// File: tb/tb_lpc_target.sv
`timescale 1ns/1ps
module tb_lpc_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_i = 1'b0;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_o;
  logic        lad_oe;
  logic        req_o;
  logic [1:0]  kind_o;
  logic [31:0] addr_o;
  logic        we_o;
  logic [7:0]  wdata_o;
  logic        ack_i = 1'b0;
  logic [7:0]  rdata_i = 8'h00;
  logic [2:0]  dma_chan_o;
  logic        dma_tc_o;

  int errors = 0;
  int checks = 0;
  logic [2:0] exp_chan = 3'd0;
  logic       exp_tc = 1'b0;

  always #4 clk = ~clk;

  lpc_target dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe(lad_oe), .req_o(req_o), .kind_o(kind_o), .addr_o(addr_o), .we_o(we_o),
    .wdata_o(wdata_o), .ack_i(ack_i), .rdata_i(rdata_i),
    .dma_chan_o(dma_chan_o), .dma_tc_o(dma_tc_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives inputs, lets one rising edge pass
  task automatic step(logic f, logic [3:0] n);
    frame_i = f;
    lad_i   = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 io, 1 mem, 2 fw, 3 dma
  task automatic run_cycle(int kind, logic we, logic [31:0] a, logic [7:0] wd,
                           logic [7:0] rd, int waits, logic [2:0] ch, logic tc,
                           logic abort_sync);
    int nn;
    logic [31:0] ea;
    if (kind == 2) step(1'b1, we ? 4'b1110 : 4'b1101);          // R1
    else begin
      step(1'b1, 4'b0000);
      if (kind == 3) step(1'b0, {2'b10, ~we, 1'b0});             // R3
      else step(1'b0, {1'b0, kind == 1, we, 1'b0});              // R2
    end
    if (kind == 3) begin
      step(1'b0, {tc, ch});
      step(1'b0, 4'b0000);
      exp_chan = ch;
      exp_tc   = tc;
    end else begin
      nn = (kind == 0) ? 4 : 8;
      for (int i = 0; i < nn; i++) step(1'b0, 4'((a >> (4 * (nn - 1 - i)))));
    end
    if (we) begin
      step(1'b0, wd[3:0]);
      step(1'b0, wd[7:4]);
    end
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    ea = (kind == 0) ? (a & 32'h0000FFFF) : a;
    check("R6 req_o after turnaround", 32'(req_o), 1);
    check("R7 sync wait code", {27'd0, lad_oe, lad_o}, {27'd0, 1'b1, 4'b0110});
    check("R2 R3 kind_o", 32'(kind_o), 32'(kind));
    check("R3 we_o", 32'(we_o), 32'(we));
    check("R4 sideband", {28'd0, dma_tc_o, dma_chan_o}, {28'd0, exp_tc, exp_chan});
    if (kind != 3) check("R5 addr_o", addr_o, ea);
    if (we) check("R6 wdata_o", 32'(wdata_o), 32'(wd));
    if (abort_sync) begin
      step(1'b1, 4'hF);
      check("R11 abort in sync releases", {30'd0, lad_oe, req_o}, 0);
      return;
    end
    for (int k = 0; k < waits; k++) begin
      step(1'b0, 4'hF);
      check("R7 long wait held", {27'd0, req_o, lad_o}, {27'd0, 1'b1, 4'b0110});
    end
    ack_i   = 1'b1;
    rdata_i = rd;
    step(1'b0, 4'hF);
    ack_i   = 1'b0;
    rdata_i = ~rd;
    check("R7 ready one clock", {26'd0, req_o, lad_oe, lad_o}, {26'd0, 1'b0, 1'b1, 4'b0000});
    if (!we) begin
      step(1'b0, 4'hF);
      check("R8 read low nibble", {27'd0, lad_oe, lad_o}, {27'd0, 1'b1, rd[3:0]});
      step(1'b0, 4'hF);
      check("R8 read high nibble", {27'd0, lad_oe, lad_o}, {27'd0, 1'b1, rd[7:4]});
    end
    step(1'b0, 4'hF);
    check("R9 turnaround park", {27'd0, lad_oe, lad_o}, {27'd0, 1'b1, 4'b1111});
    step(1'b0, 4'hF);
    check("R9 R10 released", 32'(lad_oe), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset oe", 32'(lad_oe), 0);
    check("R7 reset req", 32'(req_o), 0);
    check("R4 reset sideband", {28'd0, dma_tc_o, dma_chan_o}, 0);

    // I/O sweep, both directions
    for (int i = 0; i < 16; i++)
      run_cycle(0, i[0], 32'hABCD0000 | (32'h1111 * i), 8'(i * 13 + 5),
                8'(i * 29 + 3), i % 3, 3'd0, 1'b0, 1'b0);
    // memory, walking nibble values
    for (int i = 0; i < 8; i++)
      run_cycle(1, i[0], 32'h12345678 ^ (32'hF << (4 * i)), 8'(8'hA5 + i),
                8'(8'h3C + i), i % 2, 3'd0, 1'b0, 1'b0);
    // firmware, device-select in the top nibble
    for (int i = 0; i < 8; i++)
      run_cycle(2, i[1], {4'(i), 28'h0ACE123} ^ (32'h1 << i), 8'(i * 7),
                8'(8'hF0 - i), 1, 3'd0, 1'b0, 1'b0);
    // DMA: all channel/tc combos, both directions, each followed by an I/O cycle
    for (int i = 0; i < 32; i++) begin
      run_cycle(3, i[4], 32'h0, 8'(i * 11), 8'(i * 17 + 1), i % 2,
                3'(i), i[3], 1'b0);
      run_cycle(0, ~i[0], 32'h00000300 + i, 8'h5A, 8'hC3, 0, 3'd0, 1'b0, 1'b0);
    end

    // R1: every non-start code is ignored, followed by IO-read-like junk
    for (int v = 0; v < 16; v++) begin
      if (v == 0 || v == 13 || v == 14) continue;
      step(1'b1, 4'(v));
      for (int k = 0; k < 12; k++) begin
        step(1'b0, 4'b0000);
        check("R1 junk start ignored", {30'd0, req_o, lad_oe}, 0);
      end
    end
    // R2: illegal cycle type returns to idle
    step(1'b1, 4'b0000);
    step(1'b0, 4'b1100);
    for (int k = 0; k < 12; k++) begin
      step(1'b0, 4'b0000);
      check("R2 illegal cycle type dropped", {30'd0, req_o, lad_oe}, 0);
    end
    // R11: abort in mid-address, restart decodes cleanly
    step(1'b1, 4'b0000);
    step(1'b0, 4'b0100);
    step(1'b0, 4'h9);
    step(1'b0, 4'h8);
    run_cycle(1, 1'b1, 32'hC0FFEE11, 8'h77, 8'h00, 2, 3'd0, 1'b0, 1'b0);
    // R11: abort during sync, then a normal read
    run_cycle(0, 1'b0, 32'h000002F8, 8'h00, 8'h00, 0, 3'd0, 1'b0, 1'b1);
    step(1'b0, 4'hF);
    check("R11 idle after abort", {30'd0, req_o, lad_oe}, 0);
    run_cycle(0, 1'b0, 32'h000003F8, 8'h00, 8'h9E, 3, 3'd0, 1'b0, 1'b0);
    finish_run();
  end

endmodule